// File: doc/BRIEF.md
# Write-Back Write-Allocate Data Cache

This block is the data cache used by loads and stores in the memory stage of a pipelined processor. It is eight-way set associative, holds 64 KB in 32-byte blocks (256 sets), and talks to a main memory that has a fixed 50-cycle access time. The pipeline presents one request at a time: a byte address, a write strobe, four byte enables and a 32-bit write word. A hit completes in the cycle it is presented. A miss raises `stall`, and the pipeline holds the request steady until `stall` drops.

Loads and stores that miss are handled the same way. Both fetch the whole block, both stall for 50 cycles, and both then install the block. A store also merges its bytes into the new line and marks that line dirty. The victim is the first empty way of the set. If the set is full, the victim is the least recently used way. When the victim is dirty, its full block goes out on the write-back port in the same cycle as the install, at no extra cost. A clean victim is dropped without a memory write.

The control is a three-state machine:

- `ST_LOOKUP` compares the tags. A miss takes the *miss_detected* transition to `ST_FILL`.
- `ST_FILL` counts the memory latency. It stays put on *fill_wait*, then leaves on *fill_done* to `ST_INSTALL`.
- `ST_INSTALL` writes the block, the tag and the recency state, and issues any write-back. Its *install* transition returns to `ST_LOOKUP`.

In the cycle after the install, the held request completes as a hit.

Top module: `wb_dcache`

## Requirements
- R1: After reset every line is invalid: the first access to any address misses, and an idle cache holds `stall`, `wb_valid` and `mem_rd_en` low.
- R2: A load hit drives `stall` low and returns, in the same cycle, the 32-bit word selected by address bits 4:2 of the cached block.
- R3: A load or store miss holds `stall` high for exactly 50 cycles, starting with the request cycle. During the last 49 of those cycles, `mem_rd_en` is high and `mem_rd_addr` equals the request address with bits 4:0 cleared. The held request completes in the cycle after.
- R4: A store hit replaces byte lane i (bits 8i+7:8i of the selected word) for each set bit i of `req_be`, leaves the other bytes unchanged, and marks the line dirty.
- R5: A store miss installs the fetched block with the store's enabled bytes merged in, and the line is dirty.
- R6: An install uses the lowest-numbered invalid way of the set. If the set has no invalid way, the install replaces its least recently used block. Every hit and every install makes the accessed block the most recently used one.
- R7: When the victim is dirty, `wb_valid` is high only in the last stall cycle of the miss, with `wb_addr` equal to the victim's block address and `wb_data` equal to its full 256-bit contents. No stall cycle is added.
- R8: When the victim is clean or the way was empty, `wb_valid` stays low for the whole miss.
- R9: Bits 12:5 select the set and bits 31:13 are the tag. Addresses in the same block hit each other, and blocks in different sets never displace one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte lane enables for a store |
| req_wdata | input | 32 | Store data |
| rd_data | output | 32 | Load data on a hit |
| stall | output | 1 | Request not finished; hold it |
| mem_rd_en | output | 1 | Block fetch in progress |
| mem_rd_addr | output | 32 | Address of the block being fetched |
| mem_rd_data | input | 256 | Fetched block, sampled in the last stall cycle |
| wb_valid | output | 1 | Dirty victim being written back |
| wb_addr | output | 32 | Block address of the victim |
| wb_data | output | 256 | Full contents of the victim |

## Verification
Most corruptions of the internal state show up at the ports within one access. A bad valid or tag bit turns an expected one-cycle hit into 50 stall cycles, or the reverse, and this is visible in the very first cycle of the request. A wrong recency age shows up only when a full set evicts. The write-back then carries the wrong block address, or it appears when it should not, in the last stall cycle of that miss. A lost dirty bit or a bad byte merge stays hidden until that line is read back or evicted. For this reason the reference model compares the read data and the write-back contents on every cycle, and the stimulus revisits lines after stores and after evictions.

// File: rtl/wbdc_pkg.sv
package wbdc_pkg;

    // Sequencer states.
    // miss_detected: ST_LOOKUP  -> ST_FILL
    // fill_wait:     ST_FILL    -> ST_FILL
    // fill_done:     ST_FILL    -> ST_INSTALL
    // install:       ST_INSTALL -> ST_LOOKUP
    typedef enum logic [1:0] {
        ST_LOOKUP  = 2'd0,
        ST_FILL    = 2'd1,
        ST_INSTALL = 2'd2
    } fill_state_e;

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
    parameter int SETS  = 256,
    parameter int WAYS  = 8,
    parameter int TAG_W = 19
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(SETS)-1:0]        idx,
    input  logic [TAG_W-1:0]               cmp_tag,
    output logic [WAYS-1:0]                hit_vec,
    output logic [WAYS-1:0]                valid_vec,
    output logic [WAYS-1:0]                dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0]     tag_vec,
    input  logic                           inst_en,
    input  logic [$clog2(WAYS)-1:0]        inst_way,
    input  logic [TAG_W-1:0]               inst_tag,
    input  logic                           inst_dirty,
    input  logic                           dirty_en,
    input  logic [$clog2(WAYS)-1:0]        dirty_way
);
    logic             valid_q [SETS][WAYS];
    logic             dirty_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                    tag_q[s][w]   <= '0;
                end
            end
        end else if (inst_en) begin
            valid_q[idx][inst_way] <= 1'b1;
            dirty_q[idx][inst_way] <= inst_dirty;
            tag_q[idx][inst_way]   <= inst_tag;
        end else if (dirty_en) begin
            dirty_q[idx][dirty_way] <= 1'b1;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign valid_vec[w] = valid_q[idx][w];
        assign dirty_vec[w] = dirty_q[idx][w];
        assign tag_vec[w]   = tag_q[idx][w];
        assign hit_vec[w]   = valid_q[idx][w] && (tag_q[idx][w] == cmp_tag);
    end

    // A block is never resident in two ways of one set
    p_single_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // A dirty line is always a valid line
    p_dirty_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_vec & ~valid_vec) == '0);

endmodule

// File: rtl/dc_line_store.sv
module dc_line_store #(
    parameter int SETS   = 256,
    parameter int WAYS   = 8,
    parameter int LINE_W = 256
) (
    input  logic                        clk,
    input  logic [$clog2(SETS)-1:0]     idx,
    input  logic                        wr_en,
    input  logic [$clog2(WAYS)-1:0]     wr_way,
    input  logic [LINE_W-1:0]           wr_line,
    output logic [WAYS-1:0][LINE_W-1:0] rd_lines
);
    logic [LINE_W-1:0] line_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[idx][wr_way] <= wr_line;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_lines[w] = line_q[idx][w];
    end

endmodule

// File: rtl/dc_recency.sv
module dc_recency #(
    parameter int SETS = 256,
    parameter int WAYS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  idx,
    input  logic [WAYS-1:0]          valid_vec,
    input  logic                     touch_en,
    input  logic [$clog2(WAYS)-1:0]  touch_way,
    output logic [$clog2(WAYS)-1:0]  victim_way
);
    localparam int AGE_W = $clog2(WAYS);

    logic [AGE_W-1:0] age_q [SETS][WAYS];
    logic [AGE_W:0]   touch_age;
    logic [WAYS-1:0]  mru_vec;
    logic [WAYS-1:0]  oldest_vec;

    // An empty way counts as older than every valid way
    always_comb begin
        if (valid_vec[touch_way]) begin
            touch_age = {1'b0, age_q[idx][touch_way]};
        end else begin
            touch_age = (AGE_W + 1)'(WAYS);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= '0;
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (AGE_W'(w) == touch_way) begin
                    age_q[idx][w] <= '0;
                end else if (valid_vec[w] && ({1'b0, age_q[idx][w]} < touch_age)) begin
                    age_q[idx][w] <= age_q[idx][w] + 1'b1;
                end
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        assign mru_vec[w]    = valid_vec[w] && (age_q[idx][w] == '0);
        assign oldest_vec[w] = valid_vec[w] && (age_q[idx][w] == AGE_W'(WAYS - 1));
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_vec[w] && !found) begin
                victim_way = AGE_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (oldest_vec[w]) begin
                    victim_way = AGE_W'(w);
                end
            end
        end
    end

    // At most one valid way of a set is the most recent
    p_mru_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mru_vec));

    // A full set holds exactly one least recent way
    p_lru_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_vec) |-> ($countones(oldest_vec) == 1));

endmodule

// File: rtl/dc_fill_ctrl.sv
module dc_fill_ctrl
    import wbdc_pkg::*;
#(
    parameter int MISS_CYCLES = 50   // must be 3 or more
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        miss,
    output fill_state_e state,
    output logic        busy,
    output logic        fetching,
    output logic        installing
);
    localparam int CNT_W = $clog2(MISS_CYCLES);
    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(MISS_CYCLES - 2);

    fill_state_e      state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOOKUP;
            cnt_q <= '0;
        end else begin
            state <= state_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt_q;
        unique case (state)
            ST_LOOKUP: begin
                if (miss) begin                    // miss_detected
                    state_n = ST_FILL;
                    cnt_n   = CNT_W'(1);
                end
            end
            ST_FILL: begin
                if (cnt_q == LAST_WAIT) begin      // fill_done
                    state_n = ST_INSTALL;
                end else begin                     // fill_wait
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_INSTALL: begin                      // install
                state_n = ST_LOOKUP;
                cnt_n   = '0;
            end
            default: state_n = ST_LOOKUP;
        endcase
    end

    always_comb begin
        busy       = (state != ST_LOOKUP);
        fetching   = (state == ST_FILL) || (state == ST_INSTALL);
        installing = (state == ST_INSTALL);
    end

    p_enter_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && miss) |=> (state == ST_FILL && cnt_q == CNT_W'(1)));

    p_fill_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && cnt_q != LAST_WAIT) |=> (state == ST_FILL && cnt_q == $past(cnt_q) + 1'b1));

    p_install_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INSTALL) |=> (state == ST_LOOKUP));

endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
    import wbdc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SETS        = 256,
    parameter int WAYS        = 8,
    parameter int BLOCK_BYTES = 32,
    parameter int WORD_W      = 32,
    parameter int MISS_CYCLES = 50
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [WORD_W/8-1:0]      req_be,
    input  logic [WORD_W-1:0]        req_wdata,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     stall,
    output logic                     mem_rd_en,
    output logic [ADDR_W-1:0]        mem_rd_addr,
    input  logic [BLOCK_BYTES*8-1:0] mem_rd_data,
    output logic                     wb_valid,
    output logic [ADDR_W-1:0]        wb_addr,
    output logic [BLOCK_BYTES*8-1:0] wb_data
);
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = BLOCK_BYTES * 8;
    localparam int BE_W   = WORD_W / 8;
    localparam int BOFF_W = $clog2(BE_W);
    localparam int WSEL_W = OFF_W - BOFF_W;
    localparam int WAY_W  = $clog2(WAYS);

    fill_state_e state;
    logic        busy, fetching, installing;

    // Pending miss, captured on miss_detected
    logic [ADDR_W-1:OFF_W] pend_blk;
    logic [WSEL_W-1:0]     pend_wsel;
    logic                  pend_write;
    logic [BE_W-1:0]       pend_be;
    logic [WORD_W-1:0]     pend_wdata;
    logic [WAY_W-1:0]      pend_way;

    logic [IDX_W-1:0]               cur_idx;
    logic [TAG_W-1:0]               req_tag;
    logic [WSEL_W-1:0]              req_wsel;
    logic [WAYS-1:0]                hit_vec, valid_vec, dirty_vec;
    logic [WAYS-1:0][TAG_W-1:0]     tag_vec;
    logic [WAYS-1:0][LINE_W-1:0]    rd_lines;
    logic [WAY_W-1:0]               hit_way, victim_way;
    logic                           hit_any, lookup_hit, lookup_miss, store_hit;
    logic [LINE_W-1:0]              hit_line, fill_line, wr_line;
    logic [WAY_W-1:0]               wr_way;

    function automatic logic [LINE_W-1:0] merge_word(
        input logic [LINE_W-1:0] line,
        input logic [WSEL_W-1:0] wsel,
        input logic [BE_W-1:0]   be,
        input logic [WORD_W-1:0] wdata
    );
        logic [LINE_W-1:0] res;
        res = line;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) begin
                res[int'(wsel) * WORD_W + b * 8 +: 8] = wdata[b * 8 +: 8];
            end
        end
        return res;
    endfunction

    assign req_tag  = req_addr[ADDR_W-1:OFF_W+IDX_W];
    assign req_wsel = req_addr[OFF_W-1:BOFF_W];
    assign cur_idx  = (state == ST_LOOKUP) ? req_addr[OFF_W+IDX_W-1:OFF_W]
                                           : pend_blk[OFF_W+IDX_W-1:OFF_W];

    dc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (cur_idx),
        .cmp_tag   (req_tag),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec),
        .tag_vec   (tag_vec),
        .inst_en   (installing),
        .inst_way  (pend_way),
        .inst_tag  (pend_blk[ADDR_W-1:OFF_W+IDX_W]),
        .inst_dirty(pend_write),
        .dirty_en  (store_hit),
        .dirty_way (hit_way)
    );

    dc_line_store #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_lines (
        .clk     (clk),
        .idx     (cur_idx),
        .wr_en   (store_hit || installing),
        .wr_way  (wr_way),
        .wr_line (wr_line),
        .rd_lines(rd_lines)
    );

    dc_recency #(.SETS(SETS), .WAYS(WAYS)) u_recency (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (cur_idx),
        .valid_vec (valid_vec),
        .touch_en  (lookup_hit || installing),
        .touch_way (wr_way),
        .victim_way(victim_way)
    );

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    assign hit_any     = |hit_vec;
    assign lookup_hit  = (state == ST_LOOKUP) && req_valid && hit_any;
    assign lookup_miss = (state == ST_LOOKUP) && req_valid && !hit_any;
    assign store_hit   = lookup_hit && req_write;
    assign hit_line    = rd_lines[hit_way];

    dc_fill_ctrl #(.MISS_CYCLES(MISS_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss      (lookup_miss),
        .state     (state),
        .busy      (busy),
        .fetching  (fetching),
        .installing(installing)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_blk   <= '0;
            pend_wsel  <= '0;
            pend_write <= 1'b0;
            pend_be    <= '0;
            pend_wdata <= '0;
            pend_way   <= '0;
        end else if (lookup_miss) begin
            pend_blk   <= req_addr[ADDR_W-1:OFF_W];
            pend_wsel  <= req_wsel;
            pend_write <= req_write;
            pend_be    <= req_be;
            pend_wdata <= req_wdata;
            pend_way   <= victim_way;
        end
    end

    // Fill merges a missing store; a store hit merges into the resident line
    always_comb begin
        fill_line = pend_write ? merge_word(mem_rd_data, pend_wsel, pend_be, pend_wdata)
                               : mem_rd_data;
        if (installing) begin
            wr_way  = pend_way;
            wr_line = fill_line;
        end else begin
            wr_way  = hit_way;
            wr_line = merge_word(hit_line, req_wsel, req_be, req_wdata);
        end
    end

    always_comb begin
        stall       = busy || lookup_miss;
        rd_data     = lookup_hit ? hit_line[int'(req_wsel) * WORD_W +: WORD_W] : '0;
        mem_rd_en   = fetching;
        mem_rd_addr = {pend_blk, {OFF_W{1'b0}}};
        wb_valid    = installing && valid_vec[pend_way] && dirty_vec[pend_way];
        wb_addr     = {tag_vec[pend_way], pend_blk[OFF_W+IDX_W-1:OFF_W], {OFF_W{1'b0}}};
        wb_data     = rd_lines[pend_way];
    end

    // Write-back happens only inside a miss, never as an extra cycle
    p_wb_in_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (stall && mem_rd_en));

    // The victim is never the block being fetched
    p_wb_other_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_addr != mem_rd_addr));

    // Fetch address holds for the whole fill
    p_fetch_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !wb_valid && state == ST_FILL) |=> $stable(mem_rd_addr));

    // Install is followed by a free lookup cycle
    p_ready_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en) && state == ST_INSTALL) |=> !mem_rd_en);

endmodule

// File: tb/test_wb_dcache.sv
module test_wb_dcache;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS      = 256;
    localparam int NWAYS      = 8;
    localparam int LAT        = 50;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_write;
    logic [31:0]  req_addr;
    logic [3:0]   req_be;
    logic [31:0]  req_wdata;
    logic [31:0]  rd_data;
    logic         stall, mem_rd_en, wb_valid;
    logic [31:0]  mem_rd_addr, wb_addr;
    logic [255:0] mem_rd_data, wb_data;

    int checks = 0;
    int errors = 0;

    wb_dcache i_wb_dcache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .rd_data(rd_data),
        .stall(stall), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model: main memory, resident lines, dirty flags, recency per set
    bit [255:0]  mem_m   [int unsigned];
    bit [255:0]  line_m  [int unsigned];
    bit          dirty_m [int unsigned];
    int unsigned rec_q   [NSETS][$];

    function automatic bit [255:0] mem_rd(int unsigned b);
        bit [255:0] v;
        if (mem_m.exists(b)) return mem_m[b];
        for (int i = 0; i < 8; i++) begin
            v[i * 32 +: 32] = (b * 32'h9E3779B1 + i * 32'h01010101) ^ 32'h5A0000C3;
        end
        return v;
    endfunction

    function automatic bit [255:0] merge(bit [255:0] l, int ws, bit [3:0] be, bit [31:0] d);
        for (int i = 0; i < 4; i++) begin
            if (be[i]) l[ws * 32 + i * 8 +: 8] = d[i * 8 +: 8];
        end
        return l;
    endfunction

    function automatic int unsigned mk(int tag, int set, int word);
        return (tag << 13) | (set << 5) | (word << 2);
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    always @(negedge clk) mem_rd_data <= mem_rd(int'(mem_rd_addr >> 5));

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(stall == 1'b0, "R1", "idle stall", stall, 0);
            chk(wb_valid == 1'b0, "R1", "idle wb_valid", wb_valid, 0);
            chk(mem_rd_en == 1'b0, "R1", "idle mem_rd_en", mem_rd_en, 0);
        end
    endtask

    task automatic access(bit w, int unsigned a, bit [3:0] be, bit [31:0] d, string rq);
        int unsigned b;
        int          s, ws;
        bit          hit, evict, vd;
        int unsigned vb;
        b  = a >> 5;
        s  = b % NSETS;
        ws = (a >> 2) & 7;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
        #1;
        hit = 1'b0;
        foreach (rec_q[s][i]) if (rec_q[s][i] == b) hit = 1'b1;
        if (!hit) begin
            evict = (rec_q[s].size() == NWAYS);
            vb    = evict ? rec_q[s][NWAYS - 1] : 0;
            vd    = evict && dirty_m[vb];
            for (int k = 0; k < LAT; k++) begin
                if (k > 0) begin
                    @(negedge clk);
                    #1;
                    chk(mem_rd_en == 1'b1, "R3", "mem_rd_en during fill", mem_rd_en, 1);
                    chk(mem_rd_addr == (b << 5), "R3", "mem_rd_addr", mem_rd_addr, b << 5);
                end
                chk(stall == 1'b1, w ? "R5" : "R3", "stall during miss", stall, 1);
                if (k == LAT - 1) begin
                    chk(wb_valid == vd, vd ? "R7" : "R8", "wb_valid at install", wb_valid, vd);
                    if (vd) begin
                        chk(wb_addr == (vb << 5), "R7", "wb_addr", wb_addr, vb << 5);
                        chk(wb_data == line_m[vb], "R7", "wb_data", wb_data, line_m[vb]);
                    end
                end else begin
                    chk(wb_valid == 1'b0, "R7", "early wb_valid", wb_valid, 0);
                end
            end
            @(posedge clk);
            if (evict) begin
                if (vd) mem_m[vb] = line_m[vb];
                line_m.delete(vb);
                dirty_m.delete(vb);
                void'(rec_q[s].pop_back());
            end
            line_m[b]  = w ? merge(mem_rd(b), ws, be, d) : mem_rd(b);
            dirty_m[b] = w;
            rec_q[s].push_front(b);
            @(negedge clk);
            #1;
        end
        // Completion cycle: the block is resident
        chk(stall == 1'b0, hit ? rq : "R3", "stall at completion", stall, 0);
        chk(wb_valid == 1'b0, "R8", "wb_valid at completion", wb_valid, 0);
        if (!w) chk(rd_data == line_m[b][ws * 32 +: 32], hit ? rq : "R2", "load data",
                    rd_data, line_m[b][ws * 32 +: 32]);
        if (w) begin
            line_m[b]  = merge(line_m[b], ws, be, d);
            dirty_m[b] = 1'b1;
        end
        foreach (rec_q[s][i]) begin
            if (rec_q[s][i] == b) begin
                rec_q[s].delete(i);
                break;
            end
        end
        rec_q[s].push_front(b);
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned r;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_be = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);                                                  // R1 reset state
        access(0, mk(1, 3, 2), 4'h0, 0, "R1");                    // R1 first access misses
        access(0, mk(1, 3, 5), 4'h0, 0, "R9");                    // R9 same block, other word hits
        access(1, mk(1, 3, 5), 4'b0101, 32'hDEADBEEF, "R4");      // R4 partial store hit
        access(0, mk(1, 3, 5), 4'h0, 0, "R4");                    // R4 read back merged word
        access(1, mk(2, 3, 0), 4'b1111, 32'h12345678, "R5");      // R5 store miss
        access(0, mk(2, 3, 0), 4'h0, 0, "R5");                    // R5 merged after fill
        for (int t = 3; t <= 8; t++) access(0, mk(t, 3, t & 7), 4'h0, 0, "R6");
        access(0, mk(1, 3, 0), 4'h0, 0, "R6");                    // R6 touch makes tag 1 MRU
        access(0, mk(9, 3, 1), 4'h0, 0, "R6");                    // R7 evicts dirty tag 2
        access(0, mk(10, 3, 1), 4'h0, 0, "R6");                   // R8 evicts clean tag 3
        access(0, mk(1, 3, 7), 4'h0, 0, "R6");                    // R6 tag 1 survived
        access(0, mk(2, 4, 0), 4'h0, 0, "R9");                    // R9 other set independent
        access(0, mk(2, 3, 0), 4'h0, 0, "R7");                    // R7 written-back data returns
        idle(2);
        r = 32'h1ACE_B00C;
        for (int n = 0; n < 300; n++) begin
            int set_sel;
            r = r * 32'd1664525 + 32'd1013904223;
            set_sel = ((r >> 8) % 3 == 0) ? 0 : (((r >> 8) % 3 == 1) ? 1 : 255);
            access(r[16], mk(int'((r >> 24) % 12), set_sel, int'((r >> 12) & 7)),
                   r[23:20], r ^ 32'hC001_D00D, "R6");
        end
        idle(2);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule